// File: doc/BRIEF.md
# MII Receive Frame Parser

This block watches a 4-bit media-independent-interface receive stream, where a data-valid strobe qualifies each nibble, and turns it into framed bytes. While the strobe is high it discards the leading run of preamble nibbles. It locks onto the start-of-frame delimiter and then pairs the nibbles that follow into bytes. Every byte after the delimiter goes out on a byte port. A start marker flags the first byte, and an end marker pulses once the strobe falls.

On the way through, the block takes the first twelve bytes as the destination and source station addresses. It presents them on a side port for a forwarding engine. It also runs a CRC-32 over every nibble and counts the bytes. When the frame ends it reports a single verdict: good, runt, oversize, CRC error or collision. A downstream buffer uses that verdict to keep the frame or to drop it.

The CRC register advances on every nibble. The value used for the verdict is copied only when a byte completes, so a stray half-byte of trailing bits cannot change the outcome. A one-bit mode input chooses between two maximum frame lengths.

Top module: `mii_rx_parser`

## Requirements
- R1: After reset, and until a frame is received, out_valid, out_sof, out_eof, done and addr_valid are all low.
- R2: Nibbles seen while rxdv is high are dropped until the pair 0x5 then 0xD has arrived. The byte after that pair is the first byte output. If rxdv falls before that pair arrives, no byte is output and no done pulse occurs.
- R3: Each output byte is {second nibble, first nibble}, so the low nibble comes first. The first byte of a frame has out_sof high. out_valid rises one cycle after the clock edge that takes the byte's second nibble.
- R4: dst_addr holds bytes 0..5 with byte 0 in bits [47:40]. src_addr holds bytes 6..11 in the same order. addr_valid pulses for one cycle, one cycle after byte 11 is output. It never pulses for a frame of fewer than 12 bytes.
- R5: In the cycle after the first edge that sees rxdv low during a frame, done and out_eof both pulse for one cycle and no byte is output. status then holds the verdict: 0 good, 1 runt, 2 oversize, 3 CRC error, 4 collision.
- R6: A frame of fewer than MIN_BYTES bytes after the delimiter is reported as runt.
- R7: A frame of more than MAX_LONG bytes (long_mode=1) or more than MAX_SHORT bytes (long_mode=0) is reported as oversize.
- R8: The CRC register starts at all ones and shifts data in least significant bit first with the reflected polynomial 0xEDB88320. A frame is a CRC error when the bit-reversed register value at its last complete byte is not 0xC704DD7B.
- R9: A single trailing nibble after the last full byte gives no byte output and does not change the verdict, whatever its value.
- R10: If col is high on any nibble after the delimiter, the verdict is collision.
- R11: When several faults apply, the verdict follows the priority collision, then runt, then oversize, then CRC error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxdv | input | 1 | Receive data valid |
| rxd | input | 4 | Receive nibble |
| col | input | 1 | Collision indication |
| long_mode | input | 1 | Selects MAX_LONG (1) or MAX_SHORT (0) as the length limit |
| out_valid | output | 1 | Byte strobe |
| out_data | output | 8 | Assembled byte |
| out_sof | output | 1 | First byte of the frame |
| out_eof | output | 1 | End-of-frame pulse |
| addr_valid | output | 1 | Address pair is ready |
| dst_addr | output | 48 | Destination address |
| src_addr | output | 48 | Source address |
| done | output | 1 | Verdict strobe |
| status | output | 3 | Verdict code |

## Verification
The bench builds the block with MIN_BYTES=20, MAX_SHORT=30 and MAX_LONG=36. With these limits, a sweep of every frame length from 4 to 40 bytes in both length modes crosses the runt, good and oversize boundaries on both sides. The shortened frames also make it cheap to try all sixteen trailing-nibble values, and to corrupt one bit in every byte of a frame, including the address bytes and the check bytes. Collision and mixed-fault frames test the verdict priority.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    // verdict codes (R5)
    localparam logic [2:0] VERDICT_GOOD     = 3'd0;
    localparam logic [2:0] VERDICT_RUNT     = 3'd1;
    localparam logic [2:0] VERDICT_OVERSIZE = 3'd2;
    localparam logic [2:0] VERDICT_CRCERR   = 3'd3;
    localparam logic [2:0] VERDICT_COLL     = 3'd4;

    localparam logic [3:0]  SFD_FIRST   = 4'h5;
    localparam logic [3:0]  SFD_SECOND  = 4'hD;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_MAGIC   = 32'hC704DD7B;

    // shift one nibble into a reflected CRC-32 register, lsb first (R8)
    function automatic logic [31:0] crc_step_nibble(input logic [31:0] c,
                                                    input logic [3:0]  n);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[0] ^ n[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] reverse32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

endpackage

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       nib_en,
    input  logic [3:0] nib,
    input  logic       byte_end,
    output logic       residue_ok
);

    typedef struct packed {
        logic [31:0] run;
        logic [31:0] held;
    } crc_regs_t;

    crc_regs_t q, d;
    logic [31:0] next_run;

    always_comb begin
        next_run = crc_step_nibble(q.run, nib);
        d = q;
        if (seed)        d.run = '1;
        else if (nib_en) d.run = next_run;
        // held copy only moves on byte boundaries (R9)
        if (seed)                    d.held = '1;
        else if (nib_en && byte_end) d.held = next_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{run: '1, held: '1};
        else        q <= d;
    end

    assign residue_ok = (reverse32(q.held) == CRC_MAGIC);

endmodule

// File: rtl/mii_rx_addr.sv
module mii_rx_addr #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_stb,
    input  logic                    byte_first,
    input  logic [7:0]              byte_data,
    output logic                    addr_valid,
    output logic [ADDR_BYTES*8-1:0] dst_addr,
    output logic [ADDR_BYTES*8-1:0] src_addr
);

    localparam int AW    = ADDR_BYTES * 8;
    localparam int LAST  = 2 * ADDR_BYTES;
    localparam int IW    = $clog2(LAST + 1);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        logic          valid;
    } addr_regs_t;

    addr_regs_t q, d;
    logic [IW-1:0] pos;

    always_comb begin
        d = q;
        d.valid = 1'b0;
        pos = byte_first ? '0 : q.idx;
        if (byte_stb) begin
            if (pos < IW'(ADDR_BYTES))
                d.dst = {q.dst[AW-9:0], byte_data};
            else if (pos < IW'(LAST))
                d.src = {q.src[AW-9:0], byte_data};
            if (pos != IW'(LAST)) d.idx = pos + 1'b1;
            else                  d.idx = pos;
            d.valid = (pos == IW'(LAST - 1));   // R4
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_valid = q.valid;
    assign dst_addr   = q.dst;
    assign src_addr   = q.src;

endmodule

// File: rtl/mii_rx_parser.sv
module mii_rx_parser
    import mii_rx_pkg::*;
#(
    parameter int MIN_BYTES = 64,
    parameter int MAX_SHORT = 1518,
    parameter int MAX_LONG  = 1536
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxdv,
    input  logic [3:0]  rxd,
    input  logic        col,
    input  logic        long_mode,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    output logic        addr_valid,
    output logic [47:0] dst_addr,
    output logic [47:0] src_addr,
    output logic        done,
    output logic [2:0]  status
);

    localparam int CW = $clog2(MAX_LONG + 2);
    localparam logic [CW-1:0] CNT_SAT = CW'(MAX_LONG + 1);
    localparam logic [CW-1:0] CNT_MIN = CW'(MIN_BYTES);

    typedef struct packed {
        rx_state_e     state;
        logic [3:0]    prev;
        logic          have_lo;
        logic [3:0]    lo;
        logic [CW-1:0] cnt;
        logic          too_long;
        logic          col_seen;
        logic          valid;
        logic [7:0]    data;
        logic          sof;
        logic          eof;
        logic          done;
        logic [2:0]    status;
    } parse_regs_t;

    parse_regs_t q, d;
    logic          crc_seed, nib_en, byte_end, residue_ok;
    logic [CW-1:0] max_len;

    assign max_len = long_mode ? CW'(MAX_LONG) : CW'(MAX_SHORT);  // R7

    always_comb begin
        d = q;
        d.valid = 1'b0;
        d.sof   = 1'b0;
        d.eof   = 1'b0;
        d.done  = 1'b0;
        crc_seed = 1'b0;
        nib_en   = 1'b0;
        byte_end = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (rxdv) begin
                    d.state = ST_HUNT;
                    d.prev  = rxd;
                end
            end
            ST_HUNT: begin
                // R2: drop preamble until the delimiter pair
                if (!rxdv) begin
                    d.state = ST_IDLE;
                end else if (q.prev == SFD_FIRST && rxd == SFD_SECOND) begin
                    d.state    = ST_DATA;
                    d.have_lo  = 1'b0;
                    d.cnt      = '0;
                    d.too_long = 1'b0;
                    d.col_seen = 1'b0;
                    crc_seed   = 1'b1;
                end else begin
                    d.prev = rxd;
                end
            end
            ST_DATA: begin
                if (rxdv) begin
                    nib_en = 1'b1;
                    if (col) d.col_seen = 1'b1;              // R10
                    if (!q.have_lo) begin
                        d.lo      = rxd;
                        d.have_lo = 1'b1;
                    end else begin
                        // R3: low nibble first
                        byte_end  = 1'b1;
                        d.have_lo = 1'b0;
                        d.valid   = 1'b1;
                        d.data    = {rxd, q.lo};
                        d.sof     = (q.cnt == '0);
                        if (q.cnt == max_len) d.too_long = 1'b1;
                        if (q.cnt != CNT_SAT) d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    // R5, R11: verdict by priority
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.eof   = 1'b1;
                    if (q.col_seen)       d.status = VERDICT_COLL;
                    else if (q.cnt < CNT_MIN) d.status = VERDICT_RUNT;    // R6
                    else if (q.too_long)  d.status = VERDICT_OVERSIZE;
                    else if (!residue_ok) d.status = VERDICT_CRCERR;  // R8
                    else                  d.status = VERDICT_GOOD;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    mii_rx_crc u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed       (crc_seed),
        .nib_en     (nib_en),
        .nib        (rxd),
        .byte_end   (byte_end),
        .residue_ok (residue_ok)
    );

    mii_rx_addr #(.ADDR_BYTES(6)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_stb   (q.valid),
        .byte_first (q.sof),
        .byte_data  (q.data),
        .addr_valid (addr_valid),
        .dst_addr   (dst_addr),
        .src_addr   (src_addr)
    );

    assign out_valid = q.valid;
    assign out_data  = q.data;
    assign out_sof   = q.sof;
    assign out_eof   = q.eof;
    assign done      = q.done;
    assign status    = q.status;

endmodule

// File: rtl/mii_rx_parser_chk.sv
module mii_rx_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rxdv,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_eof,
    input logic       done,
    input logic [2:0] status,
    input logic       addr_valid
);

    // R5: verdict only after rxdv was seen low
    a_r5_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(rxdv));

    // R5: end marker never coincides with a byte
    a_r5_eof_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !out_valid);

    // R5: verdict code is one of the five defined values
    a_r5_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd4));

    // R3: bytes only come from nibbles taken while rxdv was high
    a_r3_byte_needs_dv: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rxdv));

    // R3: start marker only on a byte
    a_r3_sof_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R4: address strobe follows a byte and lasts one cycle
    a_r4_addr_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($past(out_valid) && !$past(addr_valid)));

endmodule

bind mii_rx_parser mii_rx_parser_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxdv       (rxdv),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .done       (done),
    .status     (status),
    .addr_valid (addr_valid)
);

// File: tb/mii_rx_parser_test.sv
`timescale 1ns/1ps
module mii_rx_parser_test;

    localparam int MINB = 20;
    localparam int MAXS = 30;
    localparam int MAXL = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxdv = 1'b0;
    logic [3:0]  rxd = 4'h0;
    logic        col = 1'b0;
    logic        long_mode = 1'b0;
    logic        out_valid, out_sof, out_eof, addr_valid, done;
    logic [7:0]  out_data;
    logic [47:0] dst_addr, src_addr;
    logic [2:0]  status;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mii_rx_parser #(.MIN_BYTES(MINB), .MAX_SHORT(MAXS), .MAX_LONG(MAXL)) uut (
        .clk(clk), .rst_n(rst_n), .rxdv(rxdv), .rxd(rxd), .col(col),
        .long_mode(long_mode), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .addr_valid(addr_valid),
        .dst_addr(dst_addr), .src_addr(src_addr), .done(done), .status(status)
    );

    // monitor: only this block writes these
    logic [7:0]  mon_buf [0:255];
    int          mon_bytes = 0;
    int          mon_sof_n = 0;
    int          mon_sof_at = 0;
    int          mon_done_n = 0;
    int          mon_eof_n = 0;
    int          mon_addr_n = 0;
    logic [2:0]  mon_status = 3'd0;
    logic [47:0] mon_dst = '0;
    logic [47:0] mon_src = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                mon_buf[mon_bytes % 256] = out_data;
                if (out_sof) begin
                    mon_sof_n = mon_sof_n + 1;
                    mon_sof_at = mon_bytes;
                end
                mon_bytes = mon_bytes + 1;
            end
            if (out_eof) mon_eof_n = mon_eof_n + 1;
            if (done) begin
                mon_done_n = mon_done_n + 1;
                mon_status = status;
            end
            if (addr_valid) begin
                mon_addr_n = mon_addr_n + 1;
                mon_dst = dst_addr;
                mon_src = src_addr;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    logic [7:0] fr [0:63];

    function automatic logic [31:0] bench_crc(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int b = 0; b < n; b++) begin
            c = c ^ {24'h0, fr[b]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build(input int len, input int seed);
        logic [31:0] f;
        for (int i = 0; i < len - 4; i++) fr[i] = 8'(i * 37 + seed * 11 + 3);
        f = bench_crc(len - 4);
        fr[len-4] = f[7:0];
        fr[len-3] = f[15:8];
        fr[len-2] = f[23:16];
        fr[len-1] = f[31:24];
    endtask

    task automatic drive(input logic v, input logic [3:0] n, input logic c);
        @(negedge clk);
        rxdv = v;
        rxd  = n;
        col  = c;
    endtask

    // sends fr[0..len-1]; col_at = nibble index after delimiter, -1 for none
    task automatic send(input int len, input int drib, input logic [3:0] dn,
                        input int col_at, input int lead);
        if (lead != 0) drive(1'b1, 4'h3, 1'b0);
        for (int i = 0; i < 15; i++) drive(1'b1, 4'h5, 1'b0);
        drive(1'b1, 4'hD, 1'b0);
        for (int b = 0; b < len; b++) begin
            drive(1'b1, fr[b][3:0], (2*b) == col_at);
            drive(1'b1, fr[b][7:4], (2*b+1) == col_at);
        end
        if (drib != 0) drive(1'b1, dn, 1'b0);
        drive(1'b0, 4'h0, 1'b0);
        repeat (4) drive(1'b0, 4'h0, 1'b0);
    endtask

    function automatic logic [2:0] expect_code(input int len, input logic lm,
                                               input logic crc_bad, input logic cl);
        int mx;
        mx = lm ? MAXL : MAXS;
        if (cl)           return 3'd4;
        if (len < MINB)   return 3'd1;
        if (len > mx)     return 3'd2;
        if (crc_bad)      return 3'd3;
        return 3'd0;
    endfunction

    task automatic run_frame(input int len, input logic lm, input int flip,
                             input int drib, input logic [3:0] dn,
                             input int col_at, input int lead,
                             input string vtag);
        int b0, s0, d0, e0, a0, mism;
        logic [2:0] ex;
        b0 = mon_bytes; s0 = mon_sof_n; d0 = mon_done_n;
        e0 = mon_eof_n; a0 = mon_addr_n;
        long_mode = lm;
        if (flip >= 0) fr[flip] = fr[flip] ^ (8'h1 << (flip % 8));
        send(len, drib, dn, col_at, lead);
        mism = 0;
        for (int i = 0; i < len; i++)
            if (mon_buf[(b0 + i) % 256] !== fr[i]) mism = mism + 1;
        check(mon_bytes - b0 == len, "R3", "byte count", mon_bytes - b0, len);
        check(mism == 0, "R3", "byte mismatches", mism, 0);
        check(mon_sof_n - s0 == 1 && mon_sof_at == b0, "R3", "start marker",
              mon_sof_at, b0);
        check(mon_done_n - d0 == 1 && mon_eof_n - e0 == 1, "R5", "done/eof pulses",
              mon_done_n - d0, 1);
        ex = expect_code(len, lm, flip >= 0, col_at >= 0);
        check(mon_status == ex, vtag, "verdict", mon_status, ex);
        if (len >= 12) begin
            check(mon_addr_n - a0 == 1, "R4", "addr strobe", mon_addr_n - a0, 1);
            check(mon_dst == {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]}, "R4",
                  "dst", mon_dst, {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]});
            check(mon_src == {fr[6], fr[7], fr[8], fr[9], fr[10], fr[11]}, "R4",
                  "src", mon_src, {fr[6], fr[7], fr[8], fr[9], fr[10], fr[11]});
        end else begin
            check(mon_addr_n == a0, "R4", "no addr strobe on short frame",
                  mon_addr_n - a0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int b0, d0;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sof && !out_eof && !done && !addr_valid, "R1",
              "idle during reset", {out_valid, out_sof, out_eof, done, addr_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid && !out_sof && !out_eof && !done && !addr_valid, "R1",
              "idle after reset", {out_valid, out_sof, out_eof, done, addr_valid}, 0);

        // R2: preamble dropped, rxdv falls before the delimiter
        b0 = mon_bytes; d0 = mon_done_n;
        for (int i = 0; i < 9; i++) drive(1'b1, 4'h5, 1'b0);
        repeat (4) drive(1'b0, 4'h0, 1'b0);
        check(mon_bytes == b0 && mon_done_n == d0, "R2", "no output without delimiter",
              mon_bytes - b0 + mon_done_n - d0, 0);

        // R2: leading stray nibble before the preamble
        build(24, 1);
        run_frame(24, 1'b0, -1, 0, 4'h0, -1, 1, "R2");

        // R6, R7: every length in both limit modes
        for (int lm = 0; lm < 2; lm++)
            for (int len = 4; len <= 40; len++) begin
                build(len, len + lm);
                run_frame(len, lm[0], -1, 0, 4'h0, -1, 0,
                          len < MINB ? "R6" : "R7");
            end

        // R9: every trailing nibble value on a good frame
        for (int v = 0; v < 16; v++) begin
            build(22, v);
            run_frame(22, 1'b0, -1, 1, 4'(v), -1, 0, "R9");
        end

        // R8: one bit error in every byte position
        for (int p = 0; p < 24; p++) begin
            build(24, p + 5);
            run_frame(24, 1'b0, p, 0, 4'h0, -1, 0, "R8");
        end

        // R11: runt wins over CRC, oversize wins over CRC
        build(10, 7);
        run_frame(10, 1'b0, 3, 0, 4'h0, -1, 0, "R11");
        build(34, 8);
        run_frame(34, 1'b0, 20, 0, 4'h0, -1, 0, "R11");

        // R10: collision on a good-length frame and on a runt with bad CRC
        build(26, 9);
        run_frame(26, 1'b1, -1, 0, 4'h0, 31, 0, "R10");
        build(8, 10);
        run_frame(8, 1'b0, 2, 0, 4'h0, 1, 0, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule